// File: doc/BRIEF.md
# Complementary Four-Quadrant PWM Sequencer

This block produces the gate timing for a complementary H-bridge motor drive. It takes a signed duty command and produces two switch-pair requests. The forward pair is the upper switch of phase A with the lower switch of phase B. The reverse pair is the lower switch of phase A with the upper switch of phase B. In every carrier cycle the forward pair conducts for the on interval and the reverse pair conducts for the rest. A zero command therefore gives an even split. The motor current then averages to zero while holding torque, with no deadband around zero. The sign of the command sets the direction of rotation, so no separate direction bit is needed.

The carrier is a triangular up/down counter whose half-period is a programmable terminal count. The carrier FSM has three states. CAR_IDLE is stopped, CAR_RISE counts up and CAR_FALL counts down. It has five named transitions:
- START: CAR_IDLE to CAR_RISE.
- APEX: CAR_RISE to CAR_FALL, at the terminal count.
- VALLEY: CAR_FALL to CAR_RISE, at count zero.
- RESYNC: CAR_RISE or CAR_FALL to CAR_RISE, on an accepted sync edge.
- HALT: any running state to CAR_IDLE.

The command and the terminal count are captured only when a new carrier cycle begins, that is on START, VALLEY or RESYNC.

An external sync edge can restart the carrier early. The restart is allowed only if the resulting cycle stays at least five sixths of the free-running period long, which means a frequency of at most 1.2 times free-running. Overcurrent cuts the drive for the remainder of the current cycle. The disable input and the undervoltage flag both remove all drive at once.

Top module: `cfq_pwm_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `fwd_pair_on`, `rev_pair_on` and `carrier_strobe` are all 0.
- R2: With the carrier running and no fault, exactly one of `fwd_pair_on` and `rev_pair_on` is 1 in every cycle. A zero command with an even `period_top` gives exactly `period_top` forward cycles in each carrier period of 2·`period_top` cycles.
- R3: The duty in 1/65536 units is 32768 + 31·`duty_cmd`, where `duty_cmd` is two's complement with 256 LSB per volt (about 12 points per volt). The forward threshold is floor(`period_top`·duty/65536), and the forward pair conducts for 2·threshold cycles per period. A positive command gives more than half the period, a negative command less.
- R4: The duty is clamped to between 3277 and 62259 (5 % and 95 %) before the threshold is taken.
- R5: A change of `duty_cmd` or `period_top` during a carrier cycle has no effect on that cycle. It takes effect from the next cycle start.
- R6: When `oc_flag` is 1 in a cycle, both pair requests are 0 in that cycle and in every later cycle of the same carrier cycle. Drive resumes at the next cycle start.
- R7: While `drive_en_n` is 1 or `uv_flag` is 1, both pair requests are 0 in the same cycle and the carrier halts. When both return to 0, the carrier restarts with a full cycle.
- R8: A rising edge of `sync_in` sampled at cycle position k (counting from 0 at the cycle start) starts a new cycle in the next clock only when 3·(k+1) ≥ 5·`period_top`. Otherwise it is ignored.
- R9: A `period_top` below 2 at a cycle start keeps the carrier in CAR_IDLE, with no strobe and no gate request.
- R10: `carrier_strobe` is 1 for exactly the first cycle of every carrier cycle. Its spacing is 2·`period_top` when free-running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_top | input | CNT_W | Carrier half-period in clocks (terminal count) |
| duty_cmd | input | CMD_W | Signed duty command, 256 LSB per volt |
| drive_en_n | input | 1 | Active-low drive enable |
| oc_flag | input | 1 | Overcurrent indication |
| uv_flag | input | 1 | Supply undervoltage indication |
| sync_in | input | 1 | External carrier sync, rising edge |
| fwd_pair_on | output | 1 | Request for upper A + lower B |
| rev_pair_on | output | 1 | Request for lower A + upper B |
| carrier_strobe | output | 1 | First cycle of each carrier cycle |

## Verification
The bench targets the sync acceptance boundary with sync edges at positions 32 and 33 of a 40-cycle period. A design with an off-by-one in the limit would either stretch the 34-cycle period back to 40 or accept an illegal early restart. It also changes the command in the middle of a cycle. A design that captures the command on every clock instead of at the cycle start would change the forward count of the running cycle.

An overcurrent pulse that lasts a single cycle must keep the drive off until the valley. A design that only gates with the live flag would resume drive at once. Both clamp extremes are driven as well: a missing clamp would give the full-scale command a forward time above 95 % or below 5 %.

// File: rtl/cfq_pkg.sv
package cfq_pkg;
    typedef enum logic [1:0] {
        CAR_IDLE = 2'd0,
        CAR_RISE = 2'd1,
        CAR_FALL = 2'd2
    } car_state_t;

    localparam int DUTY_FRAC_W = 16;
    localparam int DUTY_HALF   = 32768;
endpackage

// File: rtl/cfq_duty_map.sv
module cfq_duty_map
    import cfq_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int CMD_W  = 12,
    parameter int GAIN   = 31,
    parameter int MIN_Q  = 3277,
    parameter int MAX_Q  = 62259
) (
    input  logic signed [CMD_W-1:0] cmd,
    input  logic [CNT_W-1:0]        top,
    output logic [CNT_W-1:0]        thr
);
    localparam int MW = CMD_W + 10;
    localparam int PW = CNT_W + DUTY_FRAC_W;

    logic signed [MW-1:0]    sum_s;
    logic [DUTY_FRAC_W-1:0]  duty_q;
    logic [PW-1:0]           prod;

    always_comb begin
        sum_s = MW'(DUTY_HALF) + MW'(cmd) * MW'(GAIN);
        if (sum_s < MW'(MIN_Q)) begin
            duty_q = DUTY_FRAC_W'(MIN_Q);
        end else if (sum_s > MW'(MAX_Q)) begin
            duty_q = DUTY_FRAC_W'(MAX_Q);
        end else begin
            duty_q = sum_s[DUTY_FRAC_W-1:0];
        end
        prod = PW'(top) * PW'(duty_q);
        thr  = prod[PW-1:DUTY_FRAC_W];
    end
endmodule

// File: rtl/cfq_carrier.sv
module cfq_carrier
    import cfq_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_ok,
    input  logic             sync_in,
    input  logic [CNT_W-1:0] top_in,
    output car_state_t       st,
    output logic [CNT_W-1:0] cnt,
    output logic             load,
    output logic             strobe
);
    localparam int EL_W  = CNT_W + 1;
    localparam int CMP_W = CNT_W + 4;

    car_state_t       st_n;
    logic [CNT_W-1:0] top_q;
    logic [EL_W-1:0]  elapsed;
    logic             sync_prev;
    logic             sync_edge;
    logic             sync_ok;
    logic             end_cyc;
    logic             apex;
    logic             top_ok;

    assign sync_edge = sync_in & ~sync_prev;
    assign top_ok    = top_in >= CNT_W'(2);
    assign end_cyc   = (st == CAR_FALL) && (cnt == '0);
    assign apex      = (st == CAR_RISE) && (cnt == top_q - CNT_W'(1));
    assign sync_ok   = (st != CAR_IDLE) && sync_edge &&
                       ((CMP_W'(elapsed) + CMP_W'(1)) * CMP_W'(3) >=
                        CMP_W'(top_q) * CMP_W'(5));

    // next-state and cycle-start decision
    always_comb begin
        st_n = st;
        load = 1'b0;
        unique case (st)
            CAR_IDLE: begin
                if (run_ok && top_ok) begin
                    st_n = CAR_RISE;       // START
                    load = 1'b1;
                end
            end
            CAR_RISE, CAR_FALL: begin
                if (!run_ok) begin
                    st_n = CAR_IDLE;       // HALT
                end else if (end_cyc || sync_ok) begin
                    if (top_ok) begin
                        st_n = CAR_RISE;   // VALLEY or RESYNC
                        load = 1'b1;
                    end else begin
                        st_n = CAR_IDLE;   // HALT
                    end
                end else if (apex) begin
                    st_n = CAR_FALL;       // APEX
                end
            end
            default: st_n = CAR_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= CAR_IDLE;
        end else begin
            st <= st_n;
        end
    end

    // carrier counter, position within cycle, captured terminal count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            elapsed   <= '0;
            top_q     <= '0;
            sync_prev <= 1'b0;
        end else begin
            sync_prev <= sync_in;
            if (load) begin
                cnt     <= '0;
                elapsed <= '0;
                top_q   <= top_in;
            end else if (st_n == CAR_IDLE) begin
                cnt     <= '0;
                elapsed <= '0;
            end else begin
                elapsed <= elapsed + EL_W'(1);
                if (st == CAR_RISE && st_n == CAR_RISE) begin
                    cnt <= cnt + CNT_W'(1);
                end else if (st == CAR_FALL) begin
                    cnt <= cnt - CNT_W'(1);
                end
            end
        end
    end

    // outputs
    always_comb begin
        strobe = (st == CAR_RISE) && (elapsed == '0);
    end
endmodule

// File: rtl/cfq_gate_ctl.sv
module cfq_gate_ctl #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             running,
    input  logic [CNT_W-1:0] thr_in,
    input  logic [CNT_W-1:0] cnt,
    input  logic             drive_en_n,
    input  logic             uv_flag,
    input  logic             oc_flag,
    output logic             fwd_on,
    output logic             rev_on
);
    logic [CNT_W-1:0] thr_q;
    logic             oc_hold;
    logic             active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q   <= '0;
            oc_hold <= 1'b0;
        end else if (load) begin
            thr_q   <= thr_in;
            oc_hold <= 1'b0;
        end else if (running && oc_flag) begin
            oc_hold <= 1'b1;
        end
    end

    always_comb begin
        active = running && !drive_en_n && !uv_flag && !oc_flag && !oc_hold;
        fwd_on = active && (cnt < thr_q);
        rev_on = active && !(cnt < thr_q);
    end
endmodule

// File: rtl/cfq_pwm_seq.sv
module cfq_pwm_seq
    import cfq_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int CMD_W  = 12,
    parameter int GAIN   = 31,
    parameter int MIN_Q  = 3277,
    parameter int MAX_Q  = 62259
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        period_top,
    input  logic signed [CMD_W-1:0] duty_cmd,
    input  logic                    drive_en_n,
    input  logic                    oc_flag,
    input  logic                    uv_flag,
    input  logic                    sync_in,
    output logic                    fwd_pair_on,
    output logic                    rev_pair_on,
    output logic                    carrier_strobe
);
    car_state_t       car_st;
    logic [CNT_W-1:0] car_cnt;
    logic [CNT_W-1:0] thr_next;
    logic             cyc_load;
    logic             run_ok;
    logic             carrier_idle;

    assign run_ok       = !drive_en_n && !uv_flag;
    assign carrier_idle = (car_st == CAR_IDLE);

    cfq_duty_map #(
        .CNT_W (CNT_W),
        .CMD_W (CMD_W),
        .GAIN  (GAIN),
        .MIN_Q (MIN_Q),
        .MAX_Q (MAX_Q)
    ) u_map (
        .cmd (duty_cmd),
        .top (period_top),
        .thr (thr_next)
    );

    cfq_carrier #(.CNT_W(CNT_W)) u_car (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_ok  (run_ok),
        .sync_in (sync_in),
        .top_in  (period_top),
        .st      (car_st),
        .cnt     (car_cnt),
        .load    (cyc_load),
        .strobe  (carrier_strobe)
    );

    cfq_gate_ctl #(.CNT_W(CNT_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cyc_load),
        .running    (!carrier_idle),
        .thr_in     (thr_next),
        .cnt        (car_cnt),
        .drive_en_n (drive_en_n),
        .uv_flag    (uv_flag),
        .oc_flag    (oc_flag),
        .fwd_on     (fwd_pair_on),
        .rev_on     (rev_pair_on)
    );
endmodule

// File: rtl/cfq_pwm_seq_chk.sv
module cfq_pwm_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic drive_en_n,
    input logic uv_flag,
    input logic oc_flag,
    input logic fwd_pair_on,
    input logic rev_pair_on,
    input logic carrier_strobe,
    input logic carrier_idle
);
    AST_PAIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_pair_on && rev_pair_on));                                   // R2

    AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en_n || uv_flag) |-> (!fwd_pair_on && !rev_pair_on));     // R7

    AST_OC_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        oc_flag |=> (carrier_strobe || (!fwd_pair_on && !rev_pair_on))); // R6

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        carrier_strobe |=> !carrier_strobe);                              // R10

    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        carrier_idle |-> (!fwd_pair_on && !rev_pair_on && !carrier_strobe)); // R9
endmodule

bind cfq_pwm_seq cfq_pwm_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .drive_en_n     (drive_en_n),
    .uv_flag        (uv_flag),
    .oc_flag        (oc_flag),
    .fwd_pair_on    (fwd_pair_on),
    .rev_pair_on    (rev_pair_on),
    .carrier_strobe (carrier_strobe),
    .carrier_idle   (carrier_idle)
);

// File: tb/sim_cfq_pwm_seq.sv
`timescale 1ns/1ps
module sim_cfq_pwm_seq;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [9:0]        period_top = 10'd20;
    logic signed [11:0] duty_cmd = '0;
    logic              drive_en_n = 1'b1;
    logic              oc_flag = 1'b0;
    logic              uv_flag = 1'b0;
    logic              sync_in = 1'b0;
    logic              fwd_pair_on, rev_pair_on, carrier_strobe;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;   // 125 MHz

    cfq_pwm_seq u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .period_top     (period_top),
        .duty_cmd       (duty_cmd),
        .drive_en_n     (drive_en_n),
        .oc_flag        (oc_flag),
        .uv_flag        (uv_flag),
        .sync_in        (sync_in),
        .fwd_pair_on    (fwd_pair_on),
        .rev_pair_on    (rev_pair_on),
        .carrier_strobe (carrier_strobe)
    );

    // behavioural reference: position within cycle, not an up/down counter
    bit m_run = 0;
    int m_pos = 0;
    int m_top = 0;
    int m_thr = 0;
    bit m_oc  = 0;
    bit m_syncp = 0;

    function automatic int ref_thr(int top, int cmd);
        int d;
        d = 32768 + cmd * 31;
        if (d < 3277)  d = 3277;
        if (d > 62259) d = 62259;
        return (top * d) / 65536;
    endfunction

    task automatic m_start();
        m_run = 1; m_pos = 0; m_oc = 0;
        m_top = int'(period_top);
        m_thr = ref_thr(int'(period_top), int'(duty_cmd));
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_pos = 0; m_top = 0; m_thr = 0; m_oc = 0; m_syncp = 0;
        end else begin
            bit ok, endc, syn;
            ok = !drive_en_n && !uv_flag;
            if (!m_run) begin
                if (ok && period_top >= 2) m_start();
            end else if (!ok) begin
                m_run = 0;
            end else begin
                endc = (m_pos == 2 * m_top - 1);
                syn  = sync_in && !m_syncp && ((m_pos + 1) * 3 >= m_top * 5);
                if (endc || syn) begin
                    if (period_top >= 2) m_start(); else m_run = 0;
                end else begin
                    m_pos++;
                    if (oc_flag) m_oc = 1;
                end
            end
            m_syncp = sync_in;
        end
    end

    always @(negedge clk) begin
        bit act, e_f, e_r, e_s;
        int val;
        #1;
        val = (m_pos < m_top) ? m_pos : (2 * m_top - 1 - m_pos);
        act = m_run && !drive_en_n && !uv_flag && !oc_flag && !m_oc;
        e_f = act && (val < m_thr);
        e_r = act && !(val < m_thr);
        e_s = m_run && (m_pos == 0);
        n_cmp++;
        if ({fwd_pair_on, rev_pair_on, carrier_strobe} !== {e_f, e_r, e_s}) begin
            n_bad++;
            $display("FAIL %s fwd/rev/strobe got %b%b%b exp %b%b%b at %0t",
                     cur_req, fwd_pair_on, rev_pair_on, carrier_strobe, e_f, e_r, e_s, $time);
        end
    end

    task automatic check(string r, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got %0d exp %0d", r, got, exp);
        end
    endtask

    task automatic wait_strobe();
        do begin
            @(negedge clk); #2;
        end while (!carrier_strobe);
    endtask

    task automatic measure(output int f, output int r);
        f = 0; r = 0;
        wait_strobe();
        for (int i = 0; i < 2 * int'(period_top); i++) begin
            if (i > 0) begin @(negedge clk); #2; end
            f += int'(fwd_pair_on);
            r += int'(rev_pair_on);
        end
    endtask

    task automatic sync_len(int at, output int len);
        wait_strobe();
        len = 0;
        for (int i = 1; i < 200; i++) begin
            @(negedge clk);
            sync_in = (i == at);
            #2;
            if (carrier_strobe) begin len = i; break; end
        end
        sync_in = 0;
    endtask

    initial begin
        int f, r, cnt;
        repeat (3) @(negedge clk);
        #2;
        cur_req = "R1";
        check("R1 reset fwd", int'(fwd_pair_on), 0);
        check("R1 reset strobe", int'(carrier_strobe), 0);
        @(negedge clk);
        rst_n = 1;
        #2;
        check("R1 after reset", int'(fwd_pair_on | rev_pair_on), 0);

        cur_req = "R9";
        @(negedge clk);
        period_top = 10'd1; drive_en_n = 0;
        cnt = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); #2;
            cnt += int'(fwd_pair_on | rev_pair_on | carrier_strobe);
        end
        check("R9 top below 2 idle", cnt, 0);
        @(negedge clk);
        period_top = 10'd20;

        cur_req = "R2";
        measure(f, r);
        check("R2 zero cmd fwd", f, 20);
        check("R2 zero cmd rev", r, 20);

        cur_req = "R3";
        @(negedge clk); duty_cmd = 12'sd256;
        measure(f, r); measure(f, r);
        check("R3 +1V fwd", f, 24);
        @(negedge clk); duty_cmd = -12'sd256;
        measure(f, r); measure(f, r);
        check("R3 -1V fwd", f, 14);

        cur_req = "R4";
        @(negedge clk); duty_cmd = 12'sd2047;
        measure(f, r); measure(f, r);
        check("R4 clamp high fwd", f, 36);
        @(negedge clk); duty_cmd = -12'sd2048;
        measure(f, r); measure(f, r);
        check("R4 clamp low fwd", f, 2);

        cur_req = "R5";
        @(negedge clk); duty_cmd = 12'sd0;
        measure(f, r);
        wait_strobe();
        f = int'(fwd_pair_on);
        for (int i = 1; i < 40; i++) begin
            @(negedge clk);
            if (i == 3) duty_cmd = 12'sd2047;
            #2;
            f += int'(fwd_pair_on);
        end
        check("R5 mid-cycle change ignored", f, 20);
        measure(f, r);
        check("R5 change applied next cycle", f, 36);

        cur_req = "R6";
        @(negedge clk); duty_cmd = 12'sd0;
        measure(f, r);
        wait_strobe();
        cnt = 0;
        for (int i = 1; i < 40; i++) begin
            @(negedge clk);
            oc_flag = (i == 5);
            #2;
            if (i >= 5) cnt += int'(fwd_pair_on | rev_pair_on);
        end
        check("R6 oc cuts rest of cycle", cnt, 0);
        measure(f, r);
        check("R6 drive resumes", f + r, 40);

        cur_req = "R7";
        @(negedge clk); drive_en_n = 1;
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #2;
            cnt += int'(fwd_pair_on | rev_pair_on);
        end
        check("R7 disabled off", cnt, 0);
        @(negedge clk); drive_en_n = 0; uv_flag = 1;
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #2;
            cnt += int'(fwd_pair_on | rev_pair_on);
        end
        check("R7 undervoltage off", cnt, 0);
        @(negedge clk); uv_flag = 0;
        measure(f, r);
        check("R7 restart full cycle", f, 20);

        cur_req = "R8";
        sync_len(10, cnt);  check("R8 early sync ignored", cnt, 40);
        sync_len(32, cnt);  check("R8 sync at 32 ignored", cnt, 40);
        sync_len(33, cnt);  check("R8 sync at 33 accepted", cnt, 34);
        sync_len(35, cnt);  check("R8 sync at 35 accepted", cnt, 36);

        cur_req = "R10";
        sync_len(0, cnt);   check("R10 free-run spacing", cnt, 40);

        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule